// File: doc/BRIEF.md
# Watchdog Timer with Sleep-Halt Control

This block is a watchdog built on a down-counter that is 12 bits wide by default. A configuration register holds four fields: a run enable, a two-bit policy that chooses which low-power states pause the count, a reset enable, and a reload value. Software arms the watchdog by setting the enable, which loads the reload value into the counter. Each tick of a single-cycle count-enable input then decrements the counter. A refresh strobe restarts the count from the reload value. When a tick finds the counter at zero, a sticky underflow flag is raised and the counter reloads.

The system reports its power state on a two-bit input. In the deepest state the count always pauses. In the two lighter sleep states the count pauses or runs as the halt policy selects. A paused counter keeps its value and resumes from it once ticks are accepted again.

A reset request is raised from the underflow flag, or from an external error input, but only while the reset enable is set. If that request is raised while the system is in a sleep state, a wake request is raised with it. All pins are plain control and status pins. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `wdog_sleep_halt`

## Requirements
- R1: After reset, `cfg_rdata_o` reads 16'hFFF0, `count_o` is 12'hFFF, and `underflow_o`, `wdt_rst_o` and `wake_o` are 0. The readback layout is bit 0 enable, bits 2:1 halt policy, bit 3 reset enable, and bits 15:4 reload.
- R2: While the enable is 0, `count_o` stays at all ones whatever `tick_i` and `refresh_i` do.
- R3: A configuration write with `cfg_en_i`=1, made while the enable is 0, loads `cfg_reload_i` into the counter on that edge. Each later `tick_i` cycle in which the count is not paused then lowers `count_o` by one.
- R4: A configuration write with `cfg_en_i`=0 clears the enable and sets `count_o` to all ones on the same edge.
- R5: While enabled, `refresh_i` reloads the counter from the stored reload value, and it wins over `tick_i`.
- R6: With halt policy 00, the count runs in power state 1 (sleep) and in power state 2 (deep-sleep1). Power state 0 is run.
- R7: With halt policy 01, the count runs in sleep and holds its value in deep-sleep1.
- R8: With halt policy 10 or 11, the count holds its value in both sleep and deep-sleep1.
- R9: In power state 3 (deep-sleep2) the count holds its value under every halt policy. After the return to run, counting resumes from the held value.
- R10: A counting tick while `count_o` is 0 sets `underflow_o` on that edge and reloads the counter. `underflow_o` stays set until a cycle with `uf_clr_i`=1 and no new underflow.
- R11: `wdt_rst_o` equals reset enable AND (`underflow_o` OR `err_i`). With the reset enable at 0, neither an underflow nor an error raises it.
- R12: `wake_o` is 1 exactly when `wdt_rst_o` is 1 and the power state is sleep or deep-sleep1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Single-cycle count enable |
| refresh_i | input | 1 | Reload the counter from the reload field |
| pwr_i | input | 2 | Power state: 0 run, 1 sleep, 2 deep-sleep1, 3 deep-sleep2 |
| err_i | input | 1 | External watchdog error |
| uf_clr_i | input | 1 | Clear the underflow flag |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_en_i | input | 1 | Enable value to write |
| cfg_halt_i | input | 2 | Halt policy value to write |
| cfg_rsten_i | input | 1 | Reset enable value to write |
| cfg_reload_i | input | CNT_W | Reload value to write |
| cfg_rdata_o | output | CNT_W+4 | Configuration readback |
| count_o | output | CNT_W | Current counter value |
| underflow_o | output | 1 | Sticky underflow flag |
| wdt_rst_o | output | 1 | Watchdog reset request |
| wake_o | output | 1 | Wake request |

## Verification
The bench builds the block with the default CNT_W of 12, so the all-ones default of 12'hFFF and the full readback word are checked as they would appear in use. It programs small reload values such as 2, 10 and 20. These bring the zero crossing, the reload on wrap and the sticky flag within a few ticks, and they leave room to show a held count in each power state under each halt policy.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [1:0] {
    PWR_RUN   = 2'd0,
    PWR_SLEEP = 2'd1,
    PWR_DS1   = 2'd2,
    PWR_DS2   = 2'd3
  } pwr_e;

  typedef struct packed {
    logic       rsten;
    logic [1:0] halt;
    logic       en;
  } wdog_ctrl_t;

  localparam int unsigned CTRL_W = $bits(wdog_ctrl_t);
endpackage

// File: rtl/wdog_cfg_reg.sv
module wdog_cfg_reg
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             en_i,
  input  logic [1:0]       halt_i,
  input  logic             rsten_i,
  input  logic [CNT_W-1:0] reload_i,
  output wdog_ctrl_t       ctrl_o,
  output logic [CNT_W-1:0] reload_o,
  output logic             start_o,
  output logic             stop_o
);
  localparam logic [CNT_W-1:0] RELOAD_RST = {CNT_W{1'b1}};

  wdog_ctrl_t       ctrl_q;
  logic [CNT_W-1:0] reload_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      reload_q <= RELOAD_RST;
    end else if (we_i) begin
      ctrl_q.en    <= en_i;
      ctrl_q.halt  <= halt_i;
      ctrl_q.rsten <= rsten_i;
      reload_q     <= reload_i;
    end
  end

  // The counter is loaded only on the transition out of the disabled state.
  assign start_o  = we_i & en_i & ~ctrl_q.en;
  assign stop_o   = we_i & ~en_i;
  assign ctrl_o   = ctrl_q;
  assign reload_o = reload_q;
endmodule

// File: rtl/wdog_halt_dec.sv
module wdog_halt_dec
  import wdog_pkg::*;
(
  input  logic [1:0] pwr_i,
  input  logic [1:0] halt_i,
  output logic       halted_o
);
  always_comb begin
    unique case (pwr_e'(pwr_i))
      PWR_RUN:   halted_o = 1'b0;
      PWR_SLEEP: halted_o = halt_i[1];
      PWR_DS1:   halted_o = |halt_i;
      PWR_DS2:   halted_o = 1'b1;
      default:   halted_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             start_i,
  input  logic [CNT_W-1:0] start_val_i,
  input  logic             stop_i,
  input  logic             refresh_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic             step_i,
  output logic [CNT_W-1:0] count_o,
  output logic             uf_o
);
  localparam logic [CNT_W-1:0] IDLE_VAL = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE      = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;
  logic             live;

  assign live = en_i & ~stop_i & ~refresh_i & step_i;
  assign uf_o = live & (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= IDLE_VAL;
    end else if (stop_i) begin
      cnt_q <= IDLE_VAL;
    end else if (start_i) begin
      cnt_q <= start_val_i;
    end else if (!en_i) begin
      cnt_q <= IDLE_VAL;
    end else if (refresh_i) begin
      cnt_q <= reload_i;
    end else if (step_i) begin
      cnt_q <= (cnt_q == '0) ? reload_i : cnt_q - ONE;
    end
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/wdog_sleep_halt.sv
module wdog_sleep_halt
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             refresh_i,
  input  logic [1:0]       pwr_i,
  input  logic             err_i,
  input  logic             uf_clr_i,
  input  logic             cfg_we_i,
  input  logic             cfg_en_i,
  input  logic [1:0]       cfg_halt_i,
  input  logic             cfg_rsten_i,
  input  logic [CNT_W-1:0] cfg_reload_i,
  output logic [CNT_W+3:0] cfg_rdata_o,
  output logic [CNT_W-1:0] count_o,
  output logic             underflow_o,
  output logic             wdt_rst_o,
  output logic             wake_o
);
  wdog_ctrl_t       ctrl;
  logic [CNT_W-1:0] reload;
  logic             start, stop, halted, uf_pulse, uf_q;

  wdog_cfg_reg #(.CNT_W(CNT_W)) i_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .en_i    (cfg_en_i),
    .halt_i  (cfg_halt_i),
    .rsten_i (cfg_rsten_i),
    .reload_i(cfg_reload_i),
    .ctrl_o  (ctrl),
    .reload_o(reload),
    .start_o (start),
    .stop_o  (stop)
  );

  wdog_halt_dec i_halt (
    .pwr_i   (pwr_i),
    .halt_i  (ctrl.halt),
    .halted_o(halted)
  );

  wdog_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (ctrl.en),
    .start_i    (start),
    .start_val_i(cfg_reload_i),
    .stop_i     (stop),
    .refresh_i  (refresh_i),
    .reload_i   (reload),
    .step_i     (tick_i & ~halted),
    .count_o    (count_o),
    .uf_o       (uf_pulse)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       uf_q <= 1'b0;
    else if (uf_pulse) uf_q <= 1'b1;
    else if (uf_clr_i) uf_q <= 1'b0;
  end

  logic in_light_sleep;
  assign in_light_sleep = (pwr_e'(pwr_i) == PWR_SLEEP) || (pwr_e'(pwr_i) == PWR_DS1);

  assign underflow_o = uf_q;
  assign wdt_rst_o   = ctrl.rsten & (uf_q | err_i);
  assign wake_o      = wdt_rst_o & in_light_sleep;
  assign cfg_rdata_o = {reload, ctrl.rsten, ctrl.halt, ctrl.en};
endmodule

// File: rtl/wdog_sleep_halt_chk.sv
module wdog_sleep_halt_chk #(
  parameter int unsigned CNT_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             refresh_i,
  input logic [1:0]       pwr_i,
  input logic             err_i,
  input logic             uf_clr_i,
  input logic             cfg_we_i,
  input logic [CNT_W+3:0] cfg_rdata_o,
  input logic [CNT_W-1:0] count_o,
  input logic             underflow_o,
  input logic             wdt_rst_o,
  input logic             wake_o
);
  logic       en_c, rsten_c;
  logic [1:0] halt_c;
  assign en_c    = cfg_rdata_o[0];
  assign halt_c  = cfg_rdata_o[2:1];
  assign rsten_c = cfg_rdata_o[3];

  a_r2_idle_all_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_c |-> count_o == {CNT_W{1'b1}});

  a_r7_hold_ds1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_c && halt_c == 2'b01 && pwr_i == 2'd2 && !cfg_we_i && !refresh_i)
      |=> $stable(count_o));

  a_r8_hold_sleep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_c && halt_c[1] && pwr_i == 2'd1 && !cfg_we_i && !refresh_i)
      |=> $stable(count_o));

  a_r9_hold_ds2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_c && pwr_i == 2'd3 && !cfg_we_i && !refresh_i) |=> $stable(count_o));

  a_r10_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (underflow_o && !uf_clr_i) |=> underflow_o);

  a_r11_gated_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rsten_c || (!underflow_o && !err_i)) |-> !wdt_rst_o);

  a_r12_wake_in_sleep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> (wdt_rst_o && (pwr_i == 2'd1 || pwr_i == 2'd2)));

  // R12: no wake from run or deep-sleep2; tick_i is only watched for activity
  a_r12_no_wake_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_i == 2'd0 || pwr_i == 2'd3) && (tick_i || !tick_i) |-> !wake_o);
endmodule

bind wdog_sleep_halt wdog_sleep_halt_chk #(.CNT_W(CNT_W)) i_chk (.*);

// File: tb/test_wdog_sleep_halt.sv
`timescale 1ns/1ps
module test_wdog_sleep_halt;
  localparam int unsigned CNT_W = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 0, refresh = 0, err = 0, uf_clr = 0;
  logic [1:0] pwr = 2'd0;
  logic cfg_we = 0, cfg_en = 0, cfg_rsten = 0;
  logic [1:0] cfg_halt = 2'd0;
  logic [CNT_W-1:0] cfg_reload = '0;
  logic [CNT_W+3:0] rdata;
  logic [CNT_W-1:0] count;
  logic underflow, wdt_rst, wake;

  int n_chk = 0, n_fail = 0;
  bit timeout = 0;

  always #10 clk = ~clk;

  wdog_sleep_halt #(.CNT_W(CNT_W)) i_wdog_sleep_halt (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .refresh_i(refresh),
    .pwr_i(pwr), .err_i(err), .uf_clr_i(uf_clr), .cfg_we_i(cfg_we),
    .cfg_en_i(cfg_en), .cfg_halt_i(cfg_halt), .cfg_rsten_i(cfg_rsten),
    .cfg_reload_i(cfg_reload), .cfg_rdata_o(rdata), .count_o(count),
    .underflow_o(underflow), .wdt_rst_o(wdt_rst), .wake_o(wake)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic en, input logic [1:0] halt, input logic rsten,
                           input logic [CNT_W-1:0] rl);
    @(negedge clk);
    cfg_we = 1; cfg_en = en; cfg_halt = halt; cfg_rsten = rsten; cfg_reload = rl;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick = 1;
    repeat (n) @(negedge clk);
    tick = 0;
  endtask

  task automatic pulse_refresh();
    @(negedge clk); refresh = 1; tick = 1;
    @(negedge clk); refresh = 0; tick = 0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); uf_clr = 1;
    @(negedge clk); uf_clr = 0;
  endtask

  task automatic t_reset();
    chk("R1 readback", 32'(rdata), 32'h0000FFF0);
    chk("R1 count", 32'(count), 32'hFFF);
    chk("R1 flags", {29'd0, underflow, wdt_rst, wake}, 32'd0);
  endtask

  task automatic t_disabled();
    ticks(5);
    pulse_refresh();
    chk("R2 idle count", 32'(count), 32'hFFF);
  endtask

  task automatic t_enable_count();
    cfg_write(1, 2'b00, 0, 12'd10);
    chk("R3 load on enable", 32'(count), 32'd10);
    ticks(3);
    chk("R3 count down", 32'(count), 32'd7);
    pulse_refresh();
    chk("R5 refresh", 32'(count), 32'd10);
    cfg_write(0, 2'b00, 0, 12'd10);
    chk("R4 disable count", 32'(count), 32'hFFF);
    chk("R4 disable readback", 32'(rdata[0]), 32'd0);
  endtask

  task automatic t_halt00();
    cfg_write(1, 2'b00, 0, 12'd20);
    pwr = 2'd1; ticks(2);
    chk("R6 sleep runs", 32'(count), 32'd18);
    pwr = 2'd2; ticks(2);
    chk("R6 ds1 runs", 32'(count), 32'd16);
    pwr = 2'd0;
    cfg_write(0, 2'b00, 0, 12'd20);
  endtask

  task automatic t_halt01();
    cfg_write(1, 2'b01, 0, 12'd20);
    pwr = 2'd1; ticks(2);
    chk("R7 sleep runs", 32'(count), 32'd18);
    pwr = 2'd2; ticks(3);
    chk("R7 ds1 holds", 32'(count), 32'd18);
    pwr = 2'd0;
  endtask

  task automatic t_halt1x();
    cfg_write(1, 2'b10, 0, 12'd20);
    chk("R8 no reload while enabled", 32'(count), 32'd18);
    pwr = 2'd1; ticks(3);
    chk("R8 sleep holds 10", 32'(count), 32'd18);
    pwr = 2'd2; ticks(3);
    chk("R8 ds1 holds 10", 32'(count), 32'd18);
    pwr = 2'd0;
    cfg_write(1, 2'b11, 0, 12'd20);
    pwr = 2'd1; ticks(2);
    chk("R8 sleep holds 11", 32'(count), 32'd18);
    pwr = 2'd0;
  endtask

  task automatic t_ds2();
    cfg_write(1, 2'b00, 0, 12'd20);
    pwr = 2'd3; ticks(4);
    chk("R9 ds2 holds", 32'(count), 32'd18);
    pwr = 2'd0; ticks(1);
    chk("R9 resume", 32'(count), 32'd17);
  endtask

  task automatic t_underflow();
    cfg_write(0, 2'b00, 0, 12'd2);
    cfg_write(1, 2'b00, 0, 12'd2);
    ticks(2);
    chk("R10 at zero no flag", {20'd0, count, 31'd0, underflow} >> 0 == 0 ? 32'd0 : {19'd0, count, underflow}, {19'd0, 12'd0, 1'b0});
    ticks(1);
    chk("R10 flag set", 32'(underflow), 32'd1);
    chk("R10 reload on wrap", 32'(count), 32'd2);
    chk("R11 no reset when disabled", 32'(wdt_rst), 32'd0);
    ticks(1);
    chk("R10 sticky", 32'(underflow), 32'd1);
    pulse_clr();
    chk("R10 cleared", 32'(underflow), 32'd0);
  endtask

  task automatic t_reset_req();
    cfg_write(1, 2'b00, 1, 12'd2);
    ticks(2);
    chk("R11 reset on underflow", 32'(wdt_rst), 32'd1);
    chk("R12 no wake in run", 32'(wake), 32'd0);
    @(negedge clk); pwr = 2'd1; #1;
    chk("R12 wake in sleep", 32'(wake), 32'd1);
    pwr = 2'd2; #1;
    chk("R12 wake in ds1", 32'(wake), 32'd1);
    pwr = 2'd3; #1;
    chk("R12 no wake in ds2", 32'(wake), 32'd0);
    pwr = 2'd0;
    pulse_clr();
    chk("R11 cleared", 32'(wdt_rst), 32'd0);
    @(negedge clk); err = 1; #1;
    chk("R11 reset on error", 32'(wdt_rst), 32'd1);
    cfg_write(1, 2'b00, 0, 12'd2);
    chk("R11 error ignored when gated", 32'(wdt_rst), 32'd0);
    err = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    fork
      begin
        t_reset();
        t_disabled();
        t_enable_count();
        t_halt00();
        t_halt01();
        t_halt1x();
        t_ds2();
        t_underflow();
        t_reset_req();
      end
      begin
        repeat (100000) @(posedge clk);
        timeout = 1;
      end
    join_any
    disable fork;
    if (timeout) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule